// File: doc/BRIEF.md
# Power-Up Auto-Address Sequencer

This block steps a chained display driver through its start-up. An asynchronous power-on reset puts the block into a defaults phase. While in that phase, the block tells the register file to load its default values. Next comes a hold-off. It lasts a fixed number of oscillator cycles, and it counts only while the external reset input is high. When the hold-off ends, a self-addressing phase begins. That phase runs on an address clock enable at one quarter of the oscillator rate, and it always lasts the same number of address clocks. When addressing ends, the block raises a done flag and pulses a request that clears the shutdown control bit of the panel configuration register, so the driver sits in shutdown.

Throughout the sequence the block reports which host bus operations are allowed. Register writes are accepted from the hold-off onward, which gives the host time to set the chain size, the row size and the panel configuration before addressing uses them. Register reads are refused during the defaults and addressing phases. The external reset input is sampled synchronously. Holding it low in any phase after the defaults phase sends the block back to the hold-off with its timer at zero. The hold-off length is a parameter (default 2,097,152 cycles), so simulation can shorten it.

Top module: `pwrup_addr_seq`

## Requirements
- R1: While porN is low the outputs are phase = 0 (defaults), loadDefaults = 1, done = 0 and shutdownSet = 0. At the first clock edge after porN rises, phase becomes 1 (hold-off) and loadDefaults falls.
- R2: In the hold-off (phase = 1) the timer advances only in cycles where rstInN is high. After HOLD_CYCLES such cycles in a row, phase becomes 2 (addressing).
- R3: During addressing, addrClkEn is high for one oscillator cycle in every four. The first pulse comes in the fourth addressing cycle. addrClkEn is never high outside phase 2.
- R4: Addressing lasts exactly 256 addrClkEn pulses (1024 oscillator cycles). Phase then becomes 3 (running).
- R5: writeOk is 1 in every phase except phase 0.
- R6: readOk is 1 in phases 1 and 3, and 0 in phases 0 and 2.
- R7: shutdownSet is high for exactly one cycle, the first cycle of phase 3. It asks the register file to clear panel configuration bit D0, where 0 means shutdown and 1 means normal operation.
- R8: done rises in the cycle after the last addrClkEn pulse and stays high until a reset.
- R9: rstInN low at a clock edge in phase 1, 2 or 3 moves the block to phase 1 with the timer at zero and clears done. No addrClkEn pulse appears in a cycle where rstInN is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| porN | input | 1 | Power-on reset, asynchronous, active low |
| rstInN | input | 1 | External reset input, sampled synchronously, active low |
| loadDefaults | output | 1 | Register file loads its defaults while high |
| phase | output | 2 | 0 defaults, 1 hold-off, 2 addressing, 3 running |
| addrClkEn | output | 1 | Address clock enable, one cycle in four during addressing |
| done | output | 1 | Addressing finished |
| shutdownSet | output | 1 | One-cycle request to clear the shutdown control bit |
| writeOk | output | 1 | Host register writes are allowed |
| readOk | output | 1 | Host register reads are allowed |

## Verification
phase, done and shutdownSet are registered, so each of them changes one clock edge after the input condition that causes it. loadDefaults, writeOk and readOk follow phase in that same cycle. addrClkEn also depends on rstInN within the current cycle. The bench therefore drives rstInN and porN at the falling edge and compares every output 1 ns later against a behavioural model, which advances only at the rising edge. Separate measurements count the hold-off cycles, the addressing cycles and the enable pulses over a clean run, and check that done and shutdownSet appear in the first running cycle.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [1:0] {
    PH_POR  = 2'd0,
    PH_HOLD = 2'd1,
    PH_ADDR = 2'd2,
    PH_RUN  = 2'd3
  } phase_e;

  typedef struct packed {
    logic clrHold;
    logic incHold;
    logic clrAddr;
    logic runAddr;
  } seqStrobe_t;

endpackage

// File: rtl/pwrseq_count.sv
module pwrseq_count
  import pwrseq_pkg::*;
#(
  parameter int HOLD_CYCLES = 2097152,
  parameter int DIV         = 4,
  parameter int ADDR_TICKS  = 256
) (
  input  logic       clk,
  input  logic       porN,
  input  seqStrobe_t strobe,
  output logic       holdLast,
  output logic       tick,
  output logic       lastTick
);
  localparam int HOLD_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
  localparam int DIV_W  = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int TICK_W = (ADDR_TICKS > 1) ? $clog2(ADDR_TICKS) : 1;

  localparam logic [HOLD_W-1:0] HOLD_END = HOLD_W'(HOLD_CYCLES - 1);
  localparam logic [DIV_W-1:0]  DIV_END  = DIV_W'(DIV - 1);
  localparam logic [TICK_W-1:0] TICK_END = TICK_W'(ADDR_TICKS - 1);

  logic [HOLD_W-1:0] holdCnt;
  logic [DIV_W-1:0]  divCnt;
  logic [TICK_W-1:0] tickCnt;

  // hold-off timer
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                holdCnt <= '0;
    else if (strobe.clrHold)  holdCnt <= '0;
    else if (strobe.incHold)  holdCnt <= holdCnt + 1'b1;
  end

  assign holdLast = strobe.incHold && (holdCnt == HOLD_END);

  // address clock divider
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                divCnt <= '0;
    else if (strobe.clrAddr)  divCnt <= '0;
    else if (strobe.runAddr)  divCnt <= (divCnt == DIV_END) ? '0 : divCnt + 1'b1;
  end

  assign tick = strobe.runAddr && (divCnt == DIV_END);

  // address clock counter
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                tickCnt <= '0;
    else if (strobe.clrAddr)  tickCnt <= '0;
    else if (tick)            tickCnt <= tickCnt + 1'b1;
  end

  assign lastTick = tick && (tickCnt == TICK_END);

  AST_HOLD_RANGE: assert property (@(posedge clk) disable iff (!porN)
    int'(holdCnt) < HOLD_CYCLES); // R2
  AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!porN)
    int'(divCnt) < DIV); // R3
  AST_TICK_IDLE: assert property (@(posedge clk) disable iff (!porN)
    strobe.clrAddr |=> (tickCnt == '0) && (divCnt == '0)); // R4
  AST_HOLD_RESTART: assert property (@(posedge clk) disable iff (!porN)
    strobe.clrHold |=> (holdCnt == '0)); // R9

endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import pwrseq_pkg::*;
(
  input  logic       clk,
  input  logic       porN,
  input  logic       rstInN,
  input  logic       holdLast,
  input  logic       tick,
  input  logic       lastTick,
  output seqStrobe_t strobe,
  output phase_e     phase,
  output logic       done,
  output logic       shutdownSet,
  output logic       loadDefaults,
  output logic       writeOk,
  output logic       readOk
);
  phase_e phaseQ, phaseD;
  logic   doneQ, shutQ;

  always_comb begin
    strobe = '0;
    phaseD = phaseQ;
    unique case (phaseQ)
      PH_POR: begin
        strobe.clrHold = 1'b1;
        strobe.clrAddr = 1'b1;
        phaseD         = PH_HOLD;
      end
      PH_HOLD: begin
        strobe.clrAddr = 1'b1;
        if (!rstInN) begin
          strobe.clrHold = 1'b1;
        end else begin
          strobe.incHold = 1'b1;
          if (holdLast) begin
            strobe.clrHold = 1'b1;
            phaseD         = PH_ADDR;
          end
        end
      end
      PH_ADDR: begin
        strobe.clrHold = 1'b1;
        if (!rstInN) begin
          strobe.clrAddr = 1'b1;
          phaseD         = PH_HOLD;
        end else begin
          strobe.runAddr = 1'b1;
          if (lastTick) phaseD = PH_RUN;
        end
      end
      PH_RUN: begin
        strobe.clrHold = 1'b1;
        strobe.clrAddr = 1'b1;
        if (!rstInN) phaseD = PH_HOLD;
      end
      default: phaseD = PH_POR;
    endcase
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      phaseQ <= PH_POR;
      doneQ  <= 1'b0;
      shutQ  <= 1'b0;
    end else begin
      phaseQ <= phaseD;
      doneQ  <= (phaseD == PH_RUN);
      shutQ  <= (phaseQ == PH_ADDR) && (phaseD == PH_RUN);
    end
  end

  assign phase        = phaseQ;
  assign done         = doneQ;
  assign shutdownSet  = shutQ;
  assign loadDefaults = (phaseQ == PH_POR);
  assign writeOk      = (phaseQ != PH_POR);
  assign readOk       = (phaseQ == PH_HOLD) || (phaseQ == PH_RUN);

  AST_CLKEN_IN_ADDR: assert property (@(posedge clk) disable iff (!porN)
    tick |-> (phaseQ == PH_ADDR) && rstInN); // R3
  AST_ABORT_TO_HOLD: assert property (@(posedge clk) disable iff (!porN)
    (!rstInN && phaseQ != PH_POR) |=> (phaseQ == PH_HOLD) && !doneQ); // R9
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!porN)
    (doneQ && rstInN) |=> doneQ); // R8
  AST_SHUT_SINGLE: assert property (@(posedge clk) disable iff (!porN)
    shutQ |=> !shutQ); // R7
  AST_RUN_AFTER_LAST: assert property (@(posedge clk) disable iff (!porN)
    (lastTick && rstInN) |=> (phaseQ == PH_RUN) && doneQ && shutQ); // R4

endmodule

// File: rtl/pwrup_addr_seq.sv
module pwrup_addr_seq
  import pwrseq_pkg::*;
#(
  parameter int HOLD_CYCLES = 2097152,
  parameter int DIV         = 4,
  parameter int ADDR_TICKS  = 256
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       rstInN,
  output logic       loadDefaults,
  output logic [1:0] phase,
  output logic       addrClkEn,
  output logic       done,
  output logic       shutdownSet,
  output logic       writeOk,
  output logic       readOk
);
  seqStrobe_t strobe;
  phase_e     phaseW;
  logic       holdLast, tick, lastTick;

  pwrseq_ctrl u_ctrl (
    .clk          (clk),
    .porN         (porN),
    .rstInN       (rstInN),
    .holdLast     (holdLast),
    .tick         (tick),
    .lastTick     (lastTick),
    .strobe       (strobe),
    .phase        (phaseW),
    .done         (done),
    .shutdownSet  (shutdownSet),
    .loadDefaults (loadDefaults),
    .writeOk      (writeOk),
    .readOk       (readOk)
  );

  pwrseq_count #(
    .HOLD_CYCLES (HOLD_CYCLES),
    .DIV         (DIV),
    .ADDR_TICKS  (ADDR_TICKS)
  ) u_count (
    .clk      (clk),
    .porN     (porN),
    .strobe   (strobe),
    .holdLast (holdLast),
    .tick     (tick),
    .lastTick (lastTick)
  );

  assign phase     = phaseW;
  assign addrClkEn = tick;

endmodule

// File: tb/sim_pwrup_addr_seq.sv
`timescale 1ns/1ps
module sim_pwrup_addr_seq;
  localparam int H = 40;
  localparam int ADDR_LEN = 1024;

  logic clk = 1'b0;
  logic porN = 1'b0;
  logic rstInN = 1'b0;
  logic loadDefaults, addrClkEn, done, shutdownSet, writeOk, readOk;
  logic [1:0] phase;

  int tests = 0;
  int fails = 0;
  int mPhase = 0, mHold = 0, mAddr = 0;
  bit mDone = 0, mShut = 0;
  int obsPhase = 0;
  bit obsEn = 0, obsDone = 0, obsShut = 0;

  always #2.5 clk = ~clk;

  pwrup_addr_seq #(.HOLD_CYCLES(H)) u0 (
    .clk(clk), .porN(porN), .rstInN(rstInN), .loadDefaults(loadDefaults),
    .phase(phase), .addrClkEn(addrClkEn), .done(done), .shutdownSet(shutdownSet),
    .writeOk(writeOk), .readOk(readOk)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    mPhase = 0; mHold = 0; mAddr = 0; mDone = 0; mShut = 0;
  endtask

  task automatic modelAdvance(input bit r);
    bit newShut = 0;
    case (mPhase)
      0: begin mPhase = 1; mHold = 0; end
      1: begin
        if (!r) mHold = 0;
        else if (mHold == H - 1) begin mPhase = 2; mAddr = 0; end
        else mHold++;
      end
      2: begin
        if (!r) begin mPhase = 1; mHold = 0; mDone = 0; end
        else if (mAddr == ADDR_LEN - 1) begin mPhase = 3; mDone = 1; newShut = 1; end
        else mAddr++;
      end
      default: begin
        if (!r) begin mPhase = 1; mHold = 0; mDone = 0; end
      end
    endcase
    mShut = newShut;
  endtask

  task automatic step(input bit p, input bit r);
    bit expEn;
    @(negedge clk);
    porN = p;
    rstInN = r;
    if (!p) modelReset();
    #1;
    expEn = (mPhase == 2) && r && ((mAddr % 4) == 3);
    chk(loadDefaults == (mPhase == 0), "R1 loadDefaults", loadDefaults, mPhase == 0);
    chk(int'(phase) == mPhase, "R2 phase", phase, mPhase);
    chk(addrClkEn == expEn, "R3 addrClkEn", addrClkEn, expEn);
    chk(done == mDone, "R8 done", done, mDone);
    chk(shutdownSet == mShut, "R7 shutdownSet", shutdownSet, mShut);
    chk(writeOk == (mPhase != 0), "R5 writeOk", writeOk, mPhase != 0);
    chk(readOk == (mPhase == 1 || mPhase == 3), "R6 readOk", readOk,
        mPhase == 1 || mPhase == 3);
    obsPhase = int'(phase);
    obsEn = addrClkEn;
    obsDone = done;
    obsShut = shutdownSet;
    @(posedge clk);
    if (p) modelAdvance(r);
  endtask

  // Measures a clean pass starting in the first hold-off cycle.
  task automatic measure();
    int n = 0;
    int en = 0;
    while (obsPhase == 1) begin n++; step(1, 1); end
    chk(n == H, "R2 hold-off length", n, H);
    n = 0;
    while (obsPhase == 2) begin n++; if (obsEn) en++; step(1, 1); end
    chk(n == ADDR_LEN, "R4 addressing length", n, ADDR_LEN);
    chk(en == 256, "R3 enable pulse count", en, 256);
    chk(obsPhase == 3, "R4 running after addressing", obsPhase, 3);
    chk(obsDone && obsShut, "R7 R8 first running cycle", {obsDone, obsShut}, 3);
  endtask

  initial begin
    // R1: reset state
    for (int i = 0; i < 3; i++) step(0, 0);
    chk(obsPhase == 0, "R1 phase in reset", obsPhase, 0);
    // R2: timer frozen while rstInN low
    for (int i = 0; i < 6; i++) step(1, 0);
    chk(obsPhase == 1, "R1 hold-off after release", obsPhase, 1);
    // R9: abort mid hold-off, then restart
    for (int i = 0; i < 20; i++) step(1, 1);
    for (int i = 0; i < 2; i++) step(1, 0);
    step(1, 1);
    while (obsPhase == 1) step(1, 1);
    // R9: abort in addressing
    for (int i = 0; i < 600; i++) step(1, 1);
    step(1, 0);
    step(1, 1);
    chk(obsPhase == 1 && !obsEn, "R9 back to hold-off", obsPhase, 1);
    measure();
    for (int i = 0; i < 50; i++) step(1, 1);
    chk(obsDone && !obsShut, "R8 done holds, R7 single pulse", {obsDone, obsShut}, 2);
    // R9: abort in running, clean pass again
    step(1, 0);
    step(1, 1);
    chk(obsPhase == 1 && !obsDone, "R9 running abort", {obsPhase, obsDone}, 2);
    measure();
    // R1: power-on reset in the middle of addressing
    while (obsPhase != 1) step(1, 0);
    step(1, 1);
    while (obsPhase == 1) step(1, 1);
    for (int i = 0; i < 100; i++) step(1, 1);
    step(0, 1);
    chk(obsPhase == 0 && !obsDone, "R1 power-on reset mid addressing", obsPhase, 0);
    step(1, 1);
    for (int i = 0; i < 5; i++) step(1, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule